// File: doc/BRIEF.md
# Dual-Link Raster Timing Generator and Line Splitter

This block produces the raster timing for a display output. That output feeds either one portrait panel or a pair of identical panels mounted side by side. A horizontal counter and a vertical counter walk the raster. The block decodes from them the horizontal sync, vertical sync and data-enable strobes, each with a polarity that is chosen by a parameter. While the raster is in the visible region, the block raises a pixel request and gives the x and y coordinates of the pixel it wants.

The pixel source answers in the same cycle on `in_data_i`. The block registers that word and steers it to one of two output channels. In single-panel mode every pixel goes to channel 0. In dual mode the visible line is twice as wide and every horizontal interval is doubled. The left half of the line goes to channel 0 and the right half goes to channel 1.

The stream rules at the edges are as follows. The raster cannot stall, so neither channel has a ready input and there is no back-pressure. The source must present the requested pixel combinationally in the request cycle. A sink must accept every word that has its valid high. Channel data is meaningful only while its valid is high.

Top module: `dlr_dual_link_raster`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, hsync, vsync and data-enable sit at their inactive levels. The request and both valids are low, x and y are zero, and the link mode is single-panel regardless of `mode_i`. The first frame after reset uses single-panel timing.
- R2: In single mode a line lasts H_ACT+H_FP+H_SYNC+H_BP clocks. Data-enable covers the first H_ACT clocks. Hsync begins H_FP clocks after data-enable ends and stays asserted for H_SYNC clocks. The defaults are 1080, 32, 32 and 32.
- R3: In dual mode (`mode_i`=1) the visible width, the front porch, the sync width and the back porch of every line are each doubled. With the defaults these are 2160, 64, 64 and 64.
- R4: A frame in either mode has V_ACT visible lines, then V_FP blank lines, then V_SYNC lines with vsync asserted, then V_BP lines. Vsync edges fall on line starts. The defaults are 1920, 8, 4 and 10.
- R5: Hsync, vsync and data-enable are active low by default. Each has its own polarity parameter, where 1 means active high.
- R6: `req_o` is high exactly while data-enable is active. During a request, x counts up by one from 0 across the line and y gives the visible line index from 0. When there is no request, x and y are both zero.
- R7: The word on `in_data_i` in a request cycle appears on exactly one channel one clock later, with that channel's valid high. No valid rises without a request in the previous cycle.
- R8: In single mode all H_ACT pixels of a line leave on channel 0, in left-to-right order, and channel 1 never asserts valid.
- R9: In dual mode, pixels with x below H_ACT leave on channel 0 and the rest leave on channel 1. Each channel carries exactly H_ACT pixels per line in left-to-right order. The two valids are never high together.
- R10: `mode_i` is sampled only on the last clock of the final front-porch line. The new mode governs the raster from the first vsync line onward. A change or a pulse on `mode_i` at any other time has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Link mode request: 0 single panel, 1 dual panel |
| in_data_i | input | DW | Pixel word answering the current request |
| hsync_o | output | 1 | Horizontal sync, polarity per HS_POL |
| vsync_o | output | 1 | Vertical sync, polarity per VS_POL |
| de_o | output | 1 | Data-enable, polarity per DE_POL |
| req_o | output | 1 | Pixel request, active high |
| x_o | output | XW | Requested pixel column |
| y_o | output | YW | Requested pixel line |
| ch0_valid_o | output | 1 | Left or only channel word valid |
| ch0_data_o | output | DW | Left or only channel pixel word |
| ch1_valid_o | output | 1 | Right channel word valid |
| ch1_data_o | output | DW | Right channel pixel word |

## Verification
The bench measures the lengths of the intervals from edge to edge instead of absolute times. These lengths are the line total, the front-porch offset, the sync width, the vertical sync and back-porch spans, and the tail from the last visible pixel to vsync. A design that failed to double one horizontal interval, or that mixed up porch and sync, shows up as a wrong count. Each channel word carries its own coordinates, so a splitter that is off by one at the halfway column sends a pixel to the wrong side or reorders a pixel. Such a splitter breaks the per-channel sequence. The mode tests change `mode_i` in the middle of the visible region and also pulse it there. A design that sampled the mode at any line boundary would stretch a line of the current frame, or would let the pulse through. Reset is also applied while dual mode is requested, to catch a design that takes the mode straight from the pin when it leaves reset.

// File: rtl/dlr_pkg.sv
package dlr_pkg;

  typedef enum logic {
    LINK_SINGLE = 1'b0,
    LINK_DUAL   = 1'b1
  } link_mode_e;

  typedef struct packed {
    logic active;
    logic sync;
  } phase_t;

endpackage

// File: rtl/dlr_wrap_counter.sv
module dlr_wrap_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  assign wrap_o = step_i && (cnt_o == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_o <= '0;
    else if (wrap_o)
      cnt_o <= '0;
    else if (step_i)
      cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/dlr_phase_decode.sv
module dlr_phase_decode
  import dlr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] act_len_i,
  input  logic [W-1:0] fp_len_i,
  input  logic [W-1:0] sync_len_i,
  output phase_t       phase_o
);

  // Interval order inside one period: visible, front porch, sync, back porch.
  logic [W-1:0] sync_lo;
  logic [W-1:0] sync_hi;

  assign sync_lo = act_len_i + fp_len_i;
  assign sync_hi = sync_lo + sync_len_i;

  assign phase_o.active = (cnt_i < act_len_i);
  assign phase_o.sync   = (cnt_i >= sync_lo) && (cnt_i < sync_hi);

endmodule

// File: rtl/dlr_lane_splitter.sv
module dlr_lane_splitter #(
  parameter int DW    = 24,
  parameter int XW    = 12,
  parameter int H_ACT = 1080,
  parameter int NCH   = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dual_i,
  input  logic                    req_i,
  input  logic [XW-1:0]           x_i,
  input  logic [DW-1:0]           data_i,
  output logic [NCH-1:0]          valid_o,
  output logic [NCH-1:0][DW-1:0]  data_o
);

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    localparam int LO = i * H_ACT;
    localparam int HI = (i + 1) * H_ACT;

    logic in_span;
    logic pick;

    assign in_span = (int'(x_i) >= LO) && (int'(x_i) < HI);
    assign pick    = req_i && (dual_i ? in_span : (i == 0));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        data_o[i]  <= '0;
      end else begin
        valid_o[i] <= pick;
        if (pick)
          data_o[i] <= data_i;
      end
    end
  end

endmodule

// File: rtl/dlr_dual_link_raster.sv
module dlr_dual_link_raster
  import dlr_pkg::*;
#(
  parameter int H_ACT  = 1080,
  parameter int H_FP   = 32,
  parameter int H_SYNC = 32,
  parameter int H_BP   = 32,
  parameter int V_ACT  = 1920,
  parameter int V_FP   = 8,
  parameter int V_SYNC = 4,
  parameter int V_BP   = 10,
  parameter int DW     = 24,
  parameter bit HS_POL = 1'b0,
  parameter bit VS_POL = 1'b0,
  parameter bit DE_POL = 1'b0,
  localparam int H_TOT1 = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int H_TOT2 = 2 * H_TOT1,
  localparam int V_TOT  = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int XW     = $clog2(H_TOT2 + 1),
  localparam int YW     = $clog2(V_TOT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [DW-1:0] in_data_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          req_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          ch0_valid_o,
  output logic [DW-1:0] ch0_data_o,
  output logic          ch1_valid_o,
  output logic [DW-1:0] ch1_data_o
);

  localparam int NCH        = 2;
  localparam int V_SW_FIRST = V_ACT + V_FP;

  link_mode_e mode_q;
  link_mode_e mode_s1;

  logic [XW-1:0] h_act_len, h_fp_len, h_sync_len, h_last;
  logic [XW-1:0] h_cnt;
  logic [YW-1:0] v_cnt;
  logic          h_wrap;
  logic          v_wrap;
  phase_t        h_ph;
  phase_t        v_ph;
  logic          pix_on;

  // Horizontal limits follow the active link mode.
  always_comb begin
    if (mode_q == LINK_DUAL) begin
      h_act_len  = XW'(2 * H_ACT);
      h_fp_len   = XW'(2 * H_FP);
      h_sync_len = XW'(2 * H_SYNC);
      h_last     = XW'(H_TOT2 - 1);
    end else begin
      h_act_len  = XW'(H_ACT);
      h_fp_len   = XW'(H_FP);
      h_sync_len = XW'(H_SYNC);
      h_last     = XW'(H_TOT1 - 1);
    end
  end

  dlr_wrap_counter #(.W(XW)) u_hcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (1'b1),
    .last_i (h_last),
    .cnt_o  (h_cnt),
    .wrap_o (h_wrap)
  );

  dlr_wrap_counter #(.W(YW)) u_vcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (h_wrap),
    .last_i (YW'(V_TOT - 1)),
    .cnt_o  (v_cnt),
    .wrap_o (v_wrap)
  );

  dlr_phase_decode #(.W(XW)) u_hdec (
    .cnt_i      (h_cnt),
    .act_len_i  (h_act_len),
    .fp_len_i   (h_fp_len),
    .sync_len_i (h_sync_len),
    .phase_o    (h_ph)
  );

  dlr_phase_decode #(.W(YW)) u_vdec (
    .cnt_i      (v_cnt),
    .act_len_i  (YW'(V_ACT)),
    .fp_len_i   (YW'(V_FP)),
    .sync_len_i (YW'(V_SYNC)),
    .phase_o    (v_ph)
  );

  assign pix_on = h_ph.active && v_ph.active;

  // The mode is taken only as the raster enters the first vsync line.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mode_q <= LINK_SINGLE;
    else if (h_wrap && !v_wrap && (v_cnt == YW'(V_SW_FIRST - 1)))
      mode_q <= link_mode_e'(mode_i);
  end

  // Registered timing strobes and pixel request.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= ~HS_POL;
      vsync_o <= ~VS_POL;
      de_o    <= ~DE_POL;
      req_o   <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      mode_s1 <= LINK_SINGLE;
    end else begin
      hsync_o <= h_ph.sync ~^ HS_POL;
      vsync_o <= v_ph.sync ~^ VS_POL;
      de_o    <= pix_on ~^ DE_POL;
      req_o   <= pix_on;
      x_o     <= pix_on ? h_cnt : '0;
      y_o     <= pix_on ? v_cnt : '0;
      mode_s1 <= mode_q;
    end
  end

  logic [NCH-1:0]         lane_valid;
  logic [NCH-1:0][DW-1:0] lane_data;

  dlr_lane_splitter #(
    .DW    (DW),
    .XW    (XW),
    .H_ACT (H_ACT),
    .NCH   (NCH)
  ) u_split (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dual_i  (mode_s1 == LINK_DUAL),
    .req_i   (req_o),
    .x_i     (x_o),
    .data_i  (in_data_i),
    .valid_o (lane_valid),
    .data_o  (lane_data)
  );

  assign ch0_valid_o = lane_valid[0];
  assign ch0_data_o  = lane_data[0];
  assign ch1_valid_o = lane_valid[1];
  assign ch1_data_o  = lane_data[1];

endmodule

// File: rtl/dlr_raster_chk.sv
module dlr_raster_chk #(
  parameter int XW     = 12,
  parameter int YW     = 11,
  parameter int H_ACT  = 1080,
  parameter bit DE_POL = 1'b0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          de_o,
  input logic          req_o,
  input logic [XW-1:0] x_o,
  input logic [YW-1:0] y_o,
  input logic          ch0_valid_o,
  input logic          ch1_valid_o
);

  // R6
  req_de_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (de_o == DE_POL));

  // R6
  coord_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (x_o == '0 && y_o == '0));

  // R6
  x_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> (x_o == XW'($past(x_o) + 1'b1)));

  // R7
  ch_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> (ch0_valid_o || ch1_valid_o));

  // R7
  ch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch0_valid_o || ch1_valid_o) |-> $past(req_o));

  // R9
  ch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ch0_valid_o && ch1_valid_o));

  // R9
  ch1_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch1_valid_o |-> (int'($past(x_o)) >= H_ACT));

endmodule

bind dlr_dual_link_raster dlr_raster_chk #(
  .XW     (XW),
  .YW     (YW),
  .H_ACT  (H_ACT),
  .DE_POL (DE_POL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .de_o        (de_o),
  .req_o       (req_o),
  .x_o         (x_o),
  .y_o         (y_o),
  .ch0_valid_o (ch0_valid_o),
  .ch1_valid_o (ch1_valid_o)
);

// File: tb/sim_dlr_dual_link_raster.sv
`timescale 1ns/1ps
module sim_dlr_dual_link_raster;

  localparam int HA = 8, HF = 2, HS = 3, HB = 4;
  localparam int VA = 5, VF = 2, VS = 3, VB = 1;
  localparam int DW = 16;
  localparam int XW = $clog2(2 * (HA + HF + HS + HB) + 1);
  localparam int YW = $clog2(VA + VF + VS + VB + 1);

  // columns: mode, line total, visible, hs offset, hs width, ch0 count,
  //          ch1 count, vsync cycles, back-porch cycles, frame tail cycles
  localparam int NV = 3;
  localparam int VEC [NV][10] = '{
    '{0, 17,  8, 2, 3, 8, 0,  51, 17, 43},
    '{1, 34, 16, 4, 6, 8, 8, 102, 34, 86},
    '{0, 17,  8, 2, 3, 8, 0,  51, 17, 43}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [DW-1:0] in_data;
  logic hsync, vsync, de, req;
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic c0v, c1v;
  logic [DW-1:0] c0d, c1d;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  assign in_data = {8'(y), 8'(x)};

  dlr_dual_link_raster #(
    .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .DW(DW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .in_data_i(in_data),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .req_o(req),
    .x_o(x), .y_o(y),
    .ch0_valid_o(c0v), .ch0_data_o(c0d),
    .ch1_valid_o(c1v), .ch1_data_o(c1d)
  );

  // default polarity is active low (R5)
  wire de_a = ~de;
  wire hs_a = ~hsync;
  wire vs_a = ~vsync;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_vs_start();
    logic prev;
    do begin
      prev = vs_a;
      @(negedge clk);
    end while (!(vs_a && !prev));
  endtask

  task automatic wait_line_start(input int yl);
    logic prev;
    do begin
      prev = de_a;
      @(negedge clk);
    end while (!(de_a && !prev && int'(y) == yl));
  endtask

  task automatic measure_line(input int yl, output int tot, output int act,
                              output int hsoff, output int hsw, output int n0,
                              output int n1, output int obad, output int ibad);
    int n, hss, hse;
    wait_line_start(yl);
    n = 0; act = -1; hss = -1; hse = -1; tot = -1;
    n0 = 0; n1 = 0; obad = 0; ibad = 0;
    while (tot < 0 && n < 1000) begin
      @(negedge clk);
      n++;
      if (act < 0 && !de_a) act = n;
      if (hss < 0 && hs_a) hss = n;
      if (hss >= 0 && hse < 0 && !hs_a) hse = n;
      if (c0v) begin
        if (c0d != {8'(yl), 8'(n0)}) obad++;
        n0++;
      end
      if (c1v) begin
        if (c1d != {8'(yl), 8'(HA + n1)}) obad++;
        n1++;
      end
      if (req != de_a) ibad++;
      if (!req && (x != '0 || y != '0)) ibad++;
      if (act >= 0 && de_a) tot = n;
    end
    hsoff = hss - act;
    hsw = hse - hss;
  endtask

  task automatic measure_frame(output int vsw, output int vbp,
                               output int lines, output int tail);
    int n, fall;
    logic prev;
    wait_vs_start();
    n = 0;
    do begin @(negedge clk); n++; end while (vs_a && n < 5000);
    vsw = n;
    n = 0;
    while (!de_a && n < 5000) begin @(negedge clk); n++; end
    vbp = n;
    lines = 1; fall = 0; n = 0;
    do begin
      prev = de_a;
      @(negedge clk);
      n++;
      if (de_a && !prev) lines++;
      if (!de_a && prev) fall = n;
    end while (!vs_a && n < 20000);
    tail = n - fall;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tot, act, hsoff, hsw, n0, n1, obad, ibad, vsw, vbp, lines, tail;
    // R1 and R5: reset state at inactive levels
    repeat (3) @(negedge clk);
    chk("R1 R5 hsync idle", int'(hsync), 1);
    chk("R1 R5 vsync idle", int'(vsync), 1);
    chk("R1 R5 de idle", int'(de), 1);
    chk("R1 req low", int'(req), 0);
    chk("R1 coords zero", int'(x) + int'(y), 0);
    chk("R1 valids low", int'(c0v) + int'(c1v), 0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R6 R7 R8 R9
    for (int r = 0; r < NV; r++) begin
      mode = (VEC[r][0] != 0);
      wait_vs_start();
      wait_vs_start();
      measure_line(0, tot, act, hsoff, hsw, n0, n1, obad, ibad);
      chk($sformatf("R2 R3 line total row%0d", r), tot, VEC[r][1]);
      chk($sformatf("R2 R3 visible row%0d", r), act, VEC[r][2]);
      chk($sformatf("R2 R3 front porch row%0d", r), hsoff, VEC[r][3]);
      chk($sformatf("R2 R3 hsync width row%0d", r), hsw, VEC[r][4]);
      chk($sformatf("R8 R9 ch0 count row%0d", r), n0, VEC[r][5]);
      chk($sformatf("R8 R9 ch1 count row%0d", r), n1, VEC[r][6]);
      chk($sformatf("R7 R9 pixel order row%0d", r), obad, 0);
      chk($sformatf("R6 req and coords row%0d", r), ibad, 0);
      measure_frame(vsw, vbp, lines, tail);
      chk($sformatf("R4 vsync span row%0d", r), vsw, VEC[r][7]);
      chk($sformatf("R4 back porch row%0d", r), vbp, VEC[r][8]);
      chk($sformatf("R4 visible lines row%0d", r), lines, VA);
      chk($sformatf("R4 frame tail row%0d", r), tail, VEC[r][9]);
    end

    // R10: switch to dual mid-frame, current frame keeps single timing
    wait_line_start(2);
    mode = 1'b1;
    measure_line(3, tot, act, hsoff, hsw, n0, n1, obad, ibad);
    chk("R10 no mid-frame change", tot, 17);
    chk("R10 y index kept", obad, 0);
    wait_vs_start();
    measure_line(0, tot, act, hsoff, hsw, n0, n1, obad, ibad);
    chk("R10 applied at vsync", tot, 34);

    // R10: a pulse inside the visible region is ignored
    wait_line_start(1);
    mode = 1'b0;
    wait_line_start(3);
    mode = 1'b1;
    wait_vs_start();
    measure_line(0, tot, act, hsoff, hsw, n0, n1, obad, ibad);
    chk("R10 pulse ignored", tot, 34);
    chk("R9 split after pulse", n1, 8);

    // R1: reset while dual is requested, first frame is single
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset de idle", int'(de), 1);
    chk("R1 mid-run reset valid", int'(c0v) + int'(c1v), 0);
    rst_n = 1'b1;
    measure_line(0, tot, act, hsoff, hsw, n0, n1, obad, ibad);
    chk("R1 single after reset", tot, 17);
    chk("R1 R8 ch1 silent after reset", n1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule